// File: doc/BRIEF.md
# Control Transfer Resolver

This combinational block decides where an integer core goes after the current instruction. Its inputs are the program counter, the two source register values, a sign-extended immediate, an operation class and a branch condition code. Its outputs are the transfer flag, the next program counter, the value bound for the destination register with its write enable, and a flag for a target address that is not aligned to an instruction boundary.

Two parameters shape it. `XLEN` sets the operand width. At 128 bits, each comparison is assembled from two 64-bit halves: equality from the folded difference of both halves, the signed order from the high-half difference with an overflow correction, and the unsigned order from a borrow carried out of the low half. `HAS_C` states whether 16-bit instructions exist. It decides the alignment rule and whether the short-instruction flag changes the sequential step.

Top module: `ctl_xfer_resolve`

## Requirements
- R1: For a branch (op 1), `cond_i` picks the test: 0 equal, 1 not equal, 4 signed less, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal. Codes 2 and 3 are never taken.
- R2: When a transfer takes place, `next_pc_o` is the target. Otherwise it is the sequential address. A taken branch or a JAL (op 2) targets pc plus imm.
- R3: The sequential address is pc+4. It is pc+2 when `is_short_i` is set and `HAS_C`=1. With `HAS_C`=0 the flag has no effect.
- R4: JAL always transfers and produces the sequential address as its link value.
- R5: JALR (op 3) transfers to rs1 plus imm with bit 0 cleared, and produces the sequential address as its link value.
- R6: With `HAS_C`=0, a JALR target whose bit 1 is set raises `misaligned_o`. No transfer takes place and `next_pc_o` is the sequential address.
- R7: With `HAS_C`=0, a taken branch or a JAL whose target has either of its low two bits set raises `misaligned_o` and does not transfer. A branch that is not taken never raises it. With `HAS_C`=1 the flag is never raised.
- R8: LUI (op 4) produces imm as its link value. AUIPC (op 5) produces pc plus imm. Neither op transfers, and op 0 does nothing.
- R9: `link_we_o` is high only for ops 2 to 5, only with a nonzero `rd_idx_i`, and only when `misaligned_o` is low.
- R10: In the 128-bit build, all six branch tests are exact across the half boundary. This covers a signed overflow in the high-half difference, a borrow out of the low half, and operands that differ in one half only.
- R11: When `rs2_zero_i` is set, the second operand is taken as zero whatever `rs2_val_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| rs1_val_i | input | XLEN | First source value |
| rs2_val_i | input | XLEN | Second source value |
| imm_i | input | XLEN | Sign-extended immediate |
| op_i | input | 3 | 0 none, 1 branch, 2 JAL, 3 JALR, 4 LUI, 5 AUIPC |
| cond_i | input | 3 | Branch condition code |
| rd_idx_i | input | 5 | Destination register index |
| rs2_zero_i | input | 1 | Second source is the hardwired zero register |
| is_short_i | input | 1 | Current instruction is 16 bits long |
| taken_o | output | 1 | Transfer takes place |
| next_pc_o | output | XLEN | Next program counter |
| link_val_o | output | XLEN | Value for the destination register |
| link_we_o | output | 1 | Destination write enable |
| misaligned_o | output | 1 | Target not on an instruction boundary |

## Verification
The bench builds two instances that share one set of stimuli. The first uses `XLEN`=128 with `HAS_C`=0. It reaches the split-half comparisons, including an overflowing high-half difference and a borrow from the low half, and every misalignment case. The second uses `XLEN`=32 with `HAS_C`=1. It shows that the same targets transfer without a fault, that the 2-byte sequential step applies, and that the flat compare path truncates the operands correctly.

// File: rtl/ctl_xfer_resolve.sv
module ctl_xfer_resolve #(
  parameter int XLEN  = 64,
  parameter bit HAS_C = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [2:0]      op_i,
  input  logic [2:0]      cond_i,
  input  logic [4:0]      rd_idx_i,
  input  logic            rs2_zero_i,
  input  logic            is_short_i,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            link_we_o,
  output logic            misaligned_o
);
  localparam logic [2:0] OP_BR = 3'd1, OP_JAL = 3'd2, OP_JALR = 3'd3,
                         OP_LUI = 3'd4, OP_AUIPC = 3'd5;

  logic [XLEN-1:0] b_val, seq_pc, rel_tgt, reg_sum, reg_tgt, tgt, link;
  logic is_eq, is_lt, is_ltu, cond_hit, want_jump, mis, wr;

  assign b_val   = rs2_zero_i ? '0 : rs2_val_i;
  assign seq_pc  = pc_i + ((HAS_C && is_short_i) ? XLEN'(2) : XLEN'(4));
  assign rel_tgt = pc_i + imm_i;
  assign reg_sum = rs1_val_i + imm_i;
  assign reg_tgt = {reg_sum[XLEN-1:1], 1'b0};

  generate
    if (XLEN == 128) begin : g_wide
      logic [63:0] a_lo, a_hi, b_lo, b_hi, hi_diff, ovf_fix;
      logic [64:0] hi_ext;
      logic        lo_borrow;
      assign a_lo      = rs1_val_i[63:0];
      assign a_hi      = rs1_val_i[127:64];
      assign b_lo      = b_val[63:0];
      assign b_hi      = b_val[127:64];
      assign lo_borrow = a_lo < b_lo;
      assign hi_ext    = {1'b0, a_hi} - {1'b0, b_hi} - 65'(lo_borrow);
      assign hi_diff   = hi_ext[63:0];
      assign ovf_fix   = hi_diff ^ ((hi_diff ^ a_hi) & (a_hi ^ b_hi));
      assign is_eq     = rs2_zero_i ? ((a_lo | a_hi) == 64'd0)
                                    : (((a_lo ^ b_lo) | (a_hi ^ b_hi)) == 64'd0);
      assign is_lt     = rs2_zero_i ? a_hi[63] : ovf_fix[63];
      assign is_ltu    = hi_ext[64];
    end else begin : g_flat
      assign is_eq  = rs1_val_i == b_val;
      assign is_lt  = $signed(rs1_val_i) < $signed(b_val);
      assign is_ltu = rs1_val_i < b_val;
    end
  endgenerate

  always_comb begin
    case (cond_i)
      3'd0:    cond_hit = is_eq;
      3'd1:    cond_hit = !is_eq;
      3'd4:    cond_hit = is_lt;
      3'd5:    cond_hit = !is_lt;
      3'd6:    cond_hit = is_ltu;
      3'd7:    cond_hit = !is_ltu;
      default: cond_hit = 1'b0;
    endcase
  end

  always_comb begin
    want_jump = 1'b0;
    tgt       = rel_tgt;
    mis       = 1'b0;
    link      = '0;
    wr        = 1'b0;
    case (op_i)
      OP_BR: begin
        want_jump = cond_hit;
        mis       = !HAS_C && cond_hit && (rel_tgt[1:0] != 2'b00);
      end
      OP_JAL: begin
        want_jump = 1'b1;
        mis       = !HAS_C && (rel_tgt[1:0] != 2'b00);
        link      = seq_pc;
        wr        = 1'b1;
      end
      OP_JALR: begin
        want_jump = 1'b1;
        tgt       = reg_tgt;
        mis       = !HAS_C && reg_tgt[1];
        link      = seq_pc;
        wr        = 1'b1;
      end
      OP_LUI: begin
        link = imm_i;
        wr   = 1'b1;
      end
      OP_AUIPC: begin
        link = rel_tgt;
        wr   = 1'b1;
      end
      default: ;
    endcase
  end

  assign taken_o      = want_jump && !mis;
  assign next_pc_o    = taken_o ? tgt : seq_pc;
  assign link_val_o   = link;
  assign link_we_o    = wr && (rd_idx_i != 5'd0) && !mis;
  assign misaligned_o = mis;
endmodule

// File: rtl/ctl_xfer_resolve_chk.sv
module ctl_xfer_resolve_chk #(
  parameter int XLEN  = 64,
  parameter bit HAS_C = 1'b1
) (
  input logic [XLEN-1:0] pc_i,
  input logic [2:0]      op_i,
  input logic [4:0]      rd_idx_i,
  input logic            taken_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            link_we_o,
  input logic            misaligned_o
);
  always_comb begin
    if (misaligned_o) begin
      p_fault_blocks_r9: assert (!link_we_o && !taken_o);
    end
    if (rd_idx_i == 5'd0) begin
      p_rd_zero_silent_r9: assert (!link_we_o);
    end
    if (HAS_C) begin
      p_no_fault_with_short_r7: assert (!misaligned_o);
    end
    if (op_i == 3'd3 && taken_o) begin
      p_jalr_even_r5: assert (!next_pc_o[0]);
    end
    if (!taken_o) begin
      p_fallthrough_r3: assert (next_pc_o == pc_i + XLEN'(4) ||
                                (HAS_C && next_pc_o == pc_i + XLEN'(2)));
    end
    if (op_i == 3'd0 || op_i == 3'd4 || op_i == 3'd5) begin
      p_no_jump_r8: assert (!taken_o && !misaligned_o);
    end
  end
endmodule

bind ctl_xfer_resolve ctl_xfer_resolve_chk #(.XLEN(XLEN), .HAS_C(HAS_C)) u_chk (
  .pc_i(pc_i), .op_i(op_i), .rd_idx_i(rd_idx_i), .taken_o(taken_o),
  .next_pc_o(next_pc_o), .link_we_o(link_we_o), .misaligned_o(misaligned_o)
);

// File: tb/test_ctl_xfer_resolve.sv
module test_ctl_xfer_resolve;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [127:0] pc, rs1, rs2, imm;
  logic [2:0]   op, cond;
  logic [4:0]   rd;
  logic         rz, sc;

  logic         a_tk, a_we, a_mis;
  logic [127:0] a_npc, a_lnk;
  logic         b_tk, b_we, b_mis;
  logic [31:0]  b_npc, b_lnk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  ctl_xfer_resolve #(.XLEN(128), .HAS_C(1'b0)) i_ctl_xfer_resolve (
    .pc_i(pc), .rs1_val_i(rs1), .rs2_val_i(rs2), .imm_i(imm), .op_i(op),
    .cond_i(cond), .rd_idx_i(rd), .rs2_zero_i(rz), .is_short_i(sc),
    .taken_o(a_tk), .next_pc_o(a_npc), .link_val_o(a_lnk),
    .link_we_o(a_we), .misaligned_o(a_mis));

  ctl_xfer_resolve #(.XLEN(32), .HAS_C(1'b1)) i_ctl_xfer_resolve_c (
    .pc_i(pc[31:0]), .rs1_val_i(rs1[31:0]), .rs2_val_i(rs2[31:0]),
    .imm_i(imm[31:0]), .op_i(op), .cond_i(cond), .rd_idx_i(rd),
    .rs2_zero_i(rz), .is_short_i(sc),
    .taken_o(b_tk), .next_pc_o(b_npc), .link_val_o(b_lnk),
    .link_we_o(b_we), .misaligned_o(b_mis));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [2:0] c,
                       input logic [127:0] p, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] i,
                       input logic [4:0] d, input logic z, input logic s);
    @(negedge clk);
    op = o; cond = c; pc = p; rs1 = a; rs2 = b; imm = i; rd = d; rz = z; sc = s;
    #3;
  endtask

  task automatic chk_a(input string req, input logic tk, input logic [127:0] npc,
                       input logic [127:0] lnk, input logic we, input logic mis);
    chk(req, "wide taken", 128'(a_tk), 128'(tk));
    chk(req, "wide next_pc", a_npc, npc);
    chk(req, "wide link", a_lnk, lnk);
    chk(req, "wide we", 128'(a_we), 128'(we));
    chk(req, "wide misaligned", 128'(a_mis), 128'(mis));
  endtask

  task automatic chk_b(input string req, input logic tk, input logic [31:0] npc,
                       input logic [31:0] lnk, input logic we, input logic mis);
    chk(req, "narrow taken", 128'(b_tk), 128'(tk));
    chk(req, "narrow next_pc", 128'(b_npc), 128'(npc));
    chk(req, "narrow link", 128'(b_lnk), 128'(lnk));
    chk(req, "narrow we", 128'(b_we), 128'(we));
    chk(req, "narrow misaligned", 128'(b_mis), 128'(mis));
  endtask

  task automatic t_idle();
    drive(3'd0, 3'd0, 128'h500, 128'h0, 128'h0, 128'h0, 5'd3, 1'b0, 1'b0);
    chk_a("R8", 1'b0, 128'h504, 128'h0, 1'b0, 1'b0);
    chk_b("R8", 1'b0, 32'h504, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_conds();
    logic [127:0] m1 = '1;
    drive(3'd1, 3'd0, 128'h1000, 128'h7, 128'h7, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b1, 128'h1040, 128'h0, 1'b0, 1'b0);
    chk_b("R2", 1'b1, 32'h1040, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd1, 128'h1000, 128'h7, 128'h7, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b0, 128'h1004, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd4, 128'h1000, m1, 128'h1, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b1, 128'h1040, 128'h0, 1'b0, 1'b0);
    chk_b("R1", 1'b1, 32'h1040, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd5, 128'h1000, m1, 128'h1, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b0, 128'h1004, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd6, 128'h1000, m1, 128'h1, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b0, 128'h1004, 128'h0, 1'b0, 1'b0);
    chk_b("R1", 1'b0, 32'h1004, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd7, 128'h1000, m1, 128'h1, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b1, 128'h1040, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd2, 128'h1000, 128'h7, 128'h7, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_a("R1", 1'b0, 128'h1004, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd3, 128'h1000, 128'h7, 128'h9, 128'h40, 5'd1, 1'b0, 1'b0);
    chk_b("R1", 1'b0, 32'h1004, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_wide();
    logic [127:0] a, b;
    a = {64'd5, 64'd0}; b = {64'd5, 64'd1};
    drive(3'd1, 3'd0, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b0, 128'h4, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd6, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd4, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    a = {64'h8000_0000_0000_0000, 64'd0}; b = {64'd1, 64'd0};
    drive(3'd1, 3'd4, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    a = {64'h7FFF_FFFF_FFFF_FFFF, 64'd0}; b = {64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
    drive(3'd1, 3'd5, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd6, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    a = {64'd1, 64'd0}; b = {64'd0, 64'd1};
    drive(3'd1, 3'd7, 128'h0, a, b, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd1, 128'h0, {64'd2, 64'd9}, {64'd3, 64'd9}, 128'h20, 5'd0, 1'b0, 1'b0);
    chk_a("R10", 1'b1, 128'h20, 128'h0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_src();
    drive(3'd1, 3'd4, 128'h100, 128'h3, 128'h5, 128'h8, 5'd0, 1'b1, 1'b0);
    chk_a("R11", 1'b0, 128'h104, 128'h0, 1'b0, 1'b0);
    chk_b("R11", 1'b0, 32'h104, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd0, 128'h100, 128'h0, 128'h5, 128'h8, 5'd0, 1'b1, 1'b0);
    chk_a("R11", 1'b1, 128'h108, 128'h0, 1'b0, 1'b0);
    chk_b("R11", 1'b1, 32'h108, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd0, 128'h100, {64'd0, 64'd4}, 128'h0, 128'h8, 5'd0, 1'b1, 1'b0);
    chk_a("R11", 1'b0, 128'h104, 128'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd4, 128'h100, {64'hF000_0000_0000_0000, 64'd0}, 128'h5, 128'h8, 5'd0, 1'b1, 1'b0);
    chk_a("R11", 1'b1, 128'h108, 128'h0, 1'b0, 1'b0);
  endtask

  task automatic t_jal();
    drive(3'd2, 3'd0, 128'h2000, 128'h0, 128'h0, 128'h100, 5'd1, 1'b0, 1'b0);
    chk_a("R4", 1'b1, 128'h2100, 128'h2004, 1'b1, 1'b0);
    chk_b("R4", 1'b1, 32'h2100, 32'h2004, 1'b1, 1'b0);
    drive(3'd2, 3'd0, 128'h2000, 128'h0, 128'h0, 128'h102, 5'd1, 1'b0, 1'b0);
    chk_a("R7", 1'b0, 128'h2004, 128'h2004, 1'b0, 1'b1);
    chk_b("R7", 1'b1, 32'h2102, 32'h2004, 1'b1, 1'b0);
    drive(3'd2, 3'd0, 128'h2000, 128'h0, 128'h0, 128'h100, 5'd0, 1'b0, 1'b0);
    chk_a("R9", 1'b1, 128'h2100, 128'h2004, 1'b0, 1'b0);
  endtask

  task automatic t_jalr();
    drive(3'd3, 3'd0, 128'h40, 128'h3001, 128'h0, 128'h10, 5'd2, 1'b0, 1'b0);
    chk_a("R5", 1'b1, 128'h3010, 128'h44, 1'b1, 1'b0);
    chk_b("R5", 1'b1, 32'h3010, 32'h44, 1'b1, 1'b0);
    drive(3'd3, 3'd0, 128'h40, 128'h3000, 128'h0, 128'h2, 5'd2, 1'b0, 1'b0);
    chk_a("R6", 1'b0, 128'h44, 128'h44, 1'b0, 1'b1);
    chk_b("R6", 1'b1, 32'h3002, 32'h44, 1'b1, 1'b0);
    drive(3'd3, 3'd0, 128'h40, 128'h3000, 128'h0, 128'h3, 5'd2, 1'b0, 1'b0);
    chk_a("R6", 1'b0, 128'h44, 128'h44, 1'b0, 1'b1);
    drive(3'd3, 3'd0, 128'h40, 128'h3000, 128'h0, 128'h1, 5'd2, 1'b0, 1'b0);
    chk_a("R5", 1'b1, 128'h3000, 128'h44, 1'b1, 1'b0);
  endtask

  task automatic t_branch_align();
    drive(3'd1, 3'd0, 128'h800, 128'h1, 128'h1, 128'h6, 5'd0, 1'b0, 1'b0);
    chk_a("R7", 1'b0, 128'h804, 128'h0, 1'b0, 1'b1);
    chk_b("R7", 1'b1, 32'h806, 32'h0, 1'b0, 1'b0);
    drive(3'd1, 3'd1, 128'h800, 128'h1, 128'h1, 128'h6, 5'd0, 1'b0, 1'b0);
    chk_a("R7", 1'b0, 128'h804, 128'h0, 1'b0, 1'b0);
  endtask

  task automatic t_upper();
    drive(3'd4, 3'd0, 128'h1000, 128'h0, 128'h0, 128'h1234_5000, 5'd5, 1'b0, 1'b0);
    chk_a("R8", 1'b0, 128'h1004, 128'h1234_5000, 1'b1, 1'b0);
    chk_b("R8", 1'b0, 32'h1004, 32'h1234_5000, 1'b1, 1'b0);
    drive(3'd5, 3'd0, 128'h1000, 128'h0, 128'h0, 128'h1234_5000, 5'd5, 1'b0, 1'b0);
    chk_a("R8", 1'b0, 128'h1004, 128'h1234_6000, 1'b1, 1'b0);
    drive(3'd5, 3'd0, 128'h1000, 128'h0, 128'h0, 128'h1234_5000, 5'd0, 1'b0, 1'b0);
    chk_b("R9", 1'b0, 32'h1004, 32'h1234_6000, 1'b0, 1'b0);
  endtask

  task automatic t_short();
    drive(3'd0, 3'd0, 128'h600, 128'h0, 128'h0, 128'h0, 5'd1, 1'b0, 1'b1);
    chk_b("R3", 1'b0, 32'h602, 32'h0, 1'b0, 1'b0);
    chk_a("R3", 1'b0, 128'h604, 128'h0, 1'b0, 1'b0);
    drive(3'd2, 3'd0, 128'h600, 128'h0, 128'h0, 128'h20, 5'd1, 1'b0, 1'b1);
    chk_b("R3", 1'b1, 32'h620, 32'h602, 1'b1, 1'b0);
    chk_a("R3", 1'b1, 128'h620, 128'h604, 1'b1, 1'b0);
  endtask

  initial begin
    op = '0; cond = '0; pc = '0; rs1 = '0; rs2 = '0; imm = '0; rd = '0; rz = 1'b0; sc = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_conds();
    t_wide();
    t_zero_src();
    t_jal();
    t_jalr();
    t_branch_align();
    t_upper();
    t_short();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule